// File: doc/BRIEF.md
# Indirect Register-Window Bus Bridge

The bridge gives a host a small window of four 64-bit registers and turns accesses to it into single transfers on a downstream peripheral bus. The host writes a command word carrying a direction flag, a byte count and a 32-bit target address. Writing a command with the read flag set starts a downstream read at once, and the returned bytes land in the data register. Writing the data register while the stored command has the read flag clear starts a downstream write that uses the stored address and byte count. A status register tells the host when the bridge is idle again.

Data in the window register sits at its natural position inside an 8-byte aligned sector: a byte at address A sits in lane (A mod 8), counted from the most significant byte. On the downstream bus, transfer data is packed from the most significant byte: the first byte moved is in bits 63:56, the next in bits 55:48, and so on. The bridge moves bytes between the two layouts in both directions. It also clips the byte count so that no transfer crosses a sector boundary.

Downstream, the bridge is a simple request/acknowledge master. It holds one request stable until the acknowledge arrives. While a transfer is outstanding, the host is stalled on any write to the command or data register.

Top module: `regwin_bridge`

## Requirements
- R1: Window registers sit at word offsets WIN_BASE+0 (base), +1 (command), +2 (data) and +3 (status), with WIN_BASE = 0x40. Reading the command or data register returns its last latched value. Reading the base register, or any offset outside the window, returns zero. Both the command and data registers reset to zero.
- R2: Writes to the base register, to the status register and to offsets outside the window change no state and start no transfer.
- R3: Command fields: bit 63 set means read and clear means write. Bits 58:52 hold the requested byte count. Bits 31:0 hold the downstream target address.
- R4: An accepted command write with bit 63 set starts a downstream read: on the next cycle `dn_req` is high, `dn_we` is low and `dn_addr` holds the address from the command. A command write with bit 63 clear only latches the command.
- R5: An accepted data write latches the full 64-bit value. If the latched command has bit 63 clear, it also starts a downstream write with the stored address and byte count. If bit 63 is set, no transfer starts.
- R6: For a downstream write, packed byte i of `dn_wdata` (byte 0 = bits 63:56) equals lane (off+i) of the written data value, where off = address mod 8. Packed bytes at positions at or beyond `dn_len` are zero.
- R7: On the read acknowledge, the data register is loaded with packed byte i of `dn_rdata` in lane (off+i), for i below `dn_len`. All other lanes are zero.
- R8: `dn_len` is the requested count, with a count of 0 treated as 1, clipped to 8 minus off. It is never zero, and off plus `dn_len` never exceeds 8.
- R9: `dn_req`, `dn_we`, `dn_addr`, `dn_len` and `dn_wdata` stay stable while the request waits for `dn_ack`. `dn_req` is low in the cycle after the acknowledge.
- R10: Reading the status register returns bit 63 set and all other bits zero when no transfer is outstanding. It returns all zeros while a transfer is outstanding.
- R11: While a transfer is outstanding, a write to the command or data register is held with `reg_ready` low and has no effect. It takes effect once the transfer has completed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | 1 = register write, 0 = register read |
| reg_off | input | 8 | Register word offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| reg_ready | output | 1 | Low while a write is stalled behind an outstanding transfer |
| dn_req | output | 1 | Downstream request pending |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_addr | output | 32 | Downstream target address |
| dn_len | output | 4 | Downstream byte count, 1 to 8 |
| dn_wdata | output | 64 | Downstream write bytes, packed from the MSB |
| dn_ack | input | 1 | Downstream acknowledge |
| dn_rdata | input | 64 | Downstream read bytes, packed from the MSB, valid with dn_ack |

## Verification
The hardest case to reach from the ports is a second transfer-starting write that arrives while an earlier transfer is still waiting for its acknowledge. The bench reaches it by setting its responder model to a long acknowledge latency and issuing two back-to-back data writes. It then checks that the second write reports a stall, that status reads not-done during the wait, and that the second downstream write comes out only after the first has been acknowledged. The responder fills unused packed bytes of its read data with junk, so any lane that the masking fails to clear shows up in the data register.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
  localparam int unsigned BUS_BYTES = 8;
  localparam int unsigned BUS_W     = BUS_BYTES * 8;
  localparam int unsigned LANE_W    = $clog2(BUS_BYTES);
  localparam int unsigned LEN_W     = LANE_W + 1;
  localparam int unsigned XADDR_W   = 32;
  localparam int unsigned SZ_W      = 7;
  // MSB-first bit 0 is the direction flag; MSB-first bits 5..11 hold the size
  localparam int unsigned DIR_BIT   = BUS_W - 1;
  localparam int unsigned SZ_LSB    = BUS_W - 1 - 11;

  typedef struct packed {
    logic               is_read;
    logic [SZ_W-1:0]    size;
    logic [XADDR_W-1:0] addr;
  } cmd_t;

  function automatic cmd_t decode_cmd(input logic [BUS_W-1:0] w);
    cmd_t c;
    c.is_read = w[DIR_BIT];
    c.size    = w[SZ_LSB +: SZ_W];
    c.addr    = w[XADDR_W-1:0];
    return c;
  endfunction
endpackage

// File: rtl/regwin_lane_pack.sv
module regwin_lane_pack #(
  parameter int unsigned BYTES = 8,
  parameter int unsigned SZ_W  = 7,
  localparam int unsigned DW   = BYTES * 8,
  localparam int unsigned OW   = $clog2(BYTES),
  localparam int unsigned LW   = OW + 1
) (
  input  logic [OW-1:0]   off,
  input  logic [SZ_W-1:0] size,
  input  logic [DW-1:0]   lane_val,
  output logic [LW-1:0]   len,
  output logic [DW-1:0]   packed_val
);
  int room;
  int want;
  int eff;

  always_comb begin
    room = int'(BYTES) - int'(off);
    want = (size == '0) ? 1 : int'(size);
    eff  = (want > room) ? room : want;
    len  = LW'(eff);
    packed_val = '0;
    for (int i = 0; i < int'(BYTES); i++) begin
      if (i < eff) begin
        packed_val[DW-1-8*i -: 8] = lane_val[DW-1-8*(int'(off)+i) -: 8];
      end
    end
  end
endmodule

// File: rtl/regwin_lane_unpack.sv
module regwin_lane_unpack #(
  parameter int unsigned BYTES = 8,
  localparam int unsigned DW   = BYTES * 8,
  localparam int unsigned OW   = $clog2(BYTES),
  localparam int unsigned LW   = OW + 1
) (
  input  logic [OW-1:0] off,
  input  logic [LW-1:0] len,
  input  logic [DW-1:0] packed_val,
  output logic [DW-1:0] lane_val
);
  int k;

  always_comb begin
    lane_val = '0;
    k = 0;
    for (int j = 0; j < int'(BYTES); j++) begin
      k = j - int'(off);
      if (k >= 0 && k < int'(len)) begin
        lane_val[DW-1-8*j -: 8] = packed_val[DW-1-8*k -: 8];
      end
    end
  end
endmodule

// File: rtl/regwin_xfer_master.sv
module regwin_xfer_master #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 64,
  parameter int unsigned LW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_we,
  input  logic [AW-1:0] start_addr,
  input  logic [LW-1:0] start_len,
  input  logic [DW-1:0] start_wdata,
  input  logic          dn_ack,
  output logic          busy,
  output logic          rd_done,
  output logic          dn_req,
  output logic          dn_we,
  output logic [AW-1:0] dn_addr,
  output logic [LW-1:0] dn_len,
  output logic [DW-1:0] dn_wdata
);
  logic busy_q, busy_d;
  logic load_en;
  logic we_q;
  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic [DW-1:0] wdata_q;

  always_comb begin
    load_en = ~busy_q & start;
    busy_d  = busy_q;
    if (load_en) begin
      busy_d = 1'b1;
    end else if (busy_q && dn_ack) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      wdata_q <= '0;
    end else if (load_en) begin
      we_q    <= start_we;
      addr_q  <= start_addr;
      len_q   <= start_len;
      wdata_q <= start_wdata;
    end
  end

  assign busy     = busy_q;
  assign rd_done  = busy_q & dn_ack & ~we_q;
  assign dn_req   = busy_q;
  assign dn_we    = we_q;
  assign dn_addr  = addr_q;
  assign dn_len   = len_q;
  assign dn_wdata = wdata_q;
endmodule

// File: rtl/regwin_bridge.sv
module regwin_bridge
  import regwin_pkg::*;
#(
  parameter int unsigned       OFF_W    = 8,
  parameter logic [OFF_W-1:0]  WIN_BASE = 'h40
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [OFF_W-1:0]   reg_off,
  input  logic [BUS_W-1:0]   reg_wdata,
  output logic [BUS_W-1:0]   reg_rdata,
  output logic               reg_ready,
  output logic               dn_req,
  output logic               dn_we,
  output logic [XADDR_W-1:0] dn_addr,
  output logic [LEN_W-1:0]   dn_len,
  output logic [BUS_W-1:0]   dn_wdata,
  input  logic               dn_ack,
  input  logic [BUS_W-1:0]   dn_rdata
);
  localparam logic [OFF_W-1:0] OFF_BASE = WIN_BASE;
  localparam logic [OFF_W-1:0] OFF_CMD  = WIN_BASE + OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_DATA = WIN_BASE + OFF_W'(2);
  localparam logic [OFF_W-1:0] OFF_STAT = WIN_BASE + OFF_W'(3);

  logic [BUS_W-1:0] cmd_q, data_q, data_d;
  logic             cmd_en, data_en;
  logic             wr_cmd, wr_data;
  logic             busy, rd_done;
  logic             start_rd, start_wr;
  cmd_t             new_cmd, cur_cmd, src_cmd;
  logic [LEN_W-1:0] x_len;
  logic [BUS_W-1:0] x_wdata;
  logic [BUS_W-1:0] rd_lanes;

  // write decode and transfer triggers
  always_comb begin
    wr_cmd   = reg_sel & reg_we & (reg_off == OFF_CMD);
    wr_data  = reg_sel & reg_we & (reg_off == OFF_DATA);
    new_cmd  = decode_cmd(reg_wdata);
    cur_cmd  = decode_cmd(cmd_q);
    start_rd = wr_cmd & new_cmd.is_read & ~busy;
    start_wr = wr_data & ~cur_cmd.is_read & ~busy;
    src_cmd  = start_rd ? new_cmd : cur_cmd;
    reg_ready = ~((wr_cmd | wr_data) & busy);
  end

  regwin_lane_pack #(.BYTES(BUS_BYTES), .SZ_W(SZ_W)) u_pack (
    .off        (src_cmd.addr[LANE_W-1:0]),
    .size       (src_cmd.size),
    .lane_val   (reg_wdata),
    .len        (x_len),
    .packed_val (x_wdata)
  );

  regwin_xfer_master #(.AW(XADDR_W), .DW(BUS_W), .LW(LEN_W)) u_master (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_rd | start_wr),
    .start_we    (start_wr),
    .start_addr  (src_cmd.addr),
    .start_len   (x_len),
    .start_wdata (x_wdata),
    .dn_ack      (dn_ack),
    .busy        (busy),
    .rd_done     (rd_done),
    .dn_req      (dn_req),
    .dn_we       (dn_we),
    .dn_addr     (dn_addr),
    .dn_len      (dn_len),
    .dn_wdata    (dn_wdata)
  );

  regwin_lane_unpack #(.BYTES(BUS_BYTES)) u_unpack (
    .off        (dn_addr[LANE_W-1:0]),
    .len        (dn_len),
    .packed_val (dn_rdata),
    .lane_val   (rd_lanes)
  );

  // register next-state
  always_comb begin
    cmd_en  = wr_cmd & ~busy;
    data_en = (wr_data & ~busy) | rd_done;
    data_d  = rd_done ? rd_lanes : reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
    end else if (cmd_en) begin
      cmd_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (data_en) begin
      data_q <= data_d;
    end
  end

  // read mux
  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_we) begin
      unique case (reg_off)
        OFF_BASE: reg_rdata = '0;
        OFF_CMD:  reg_rdata = cmd_q;
        OFF_DATA: reg_rdata = data_q;
        OFF_STAT: reg_rdata = {~busy, {(BUS_W-1){1'b0}}};
        default:  reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/regwin_bridge_chk.sv
module regwin_bridge_chk #(
  parameter int unsigned      OFF_W    = 8,
  parameter logic [OFF_W-1:0] WIN_BASE = 'h40,
  parameter int unsigned      AW       = 32,
  parameter int unsigned      DW       = 64,
  parameter int unsigned      LW       = 4,
  parameter int unsigned      OW       = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_sel,
  input logic             reg_we,
  input logic [OFF_W-1:0] reg_off,
  input logic             wr_rd_flag,
  input logic [AW-1:0]    wr_addr,
  input logic [DW-1:0]    reg_rdata,
  input logic             reg_ready,
  input logic             dn_req,
  input logic             dn_we,
  input logic [AW-1:0]    dn_addr,
  input logic [OW-1:0]    dn_off,
  input logic [LW-1:0]    dn_len,
  input logic [DW-1:0]    dn_wdata,
  input logic             dn_ack
);
  localparam logic [OFF_W-1:0] OFF_CMD  = WIN_BASE + OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_STAT = WIN_BASE + OFF_W'(3);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_ack |=> dn_req && $stable(dn_we) && $stable(dn_addr)
                          && $stable(dn_len) && $stable(dn_wdata));

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && dn_ack |=> !dn_req);

  // R8
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req |-> (dn_len != '0) && (int'(dn_off) + int'(dn_len) <= (1 << OW)));

  // R10
  stat_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel && !reg_we && reg_off == OFF_STAT |-> reg_rdata == {!dn_req, {(DW-1){1'b0}}});

  // R11
  stall_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_ready |-> dn_req);

  // R1
  base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel && !reg_we && reg_off == WIN_BASE |-> reg_rdata == '0);

  // R4
  read_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_sel && reg_we && reg_off == OFF_CMD && wr_rd_flag && reg_ready
    |=> dn_req && !dn_we && dn_addr == $past(wr_addr));
endmodule

bind regwin_bridge regwin_bridge_chk #(
  .OFF_W(OFF_W), .WIN_BASE(WIN_BASE), .AW(regwin_pkg::XADDR_W),
  .DW(regwin_pkg::BUS_W), .LW(regwin_pkg::LEN_W), .OW(regwin_pkg::LANE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .reg_we     (reg_we),
  .reg_off    (reg_off),
  .wr_rd_flag (reg_wdata[regwin_pkg::DIR_BIT]),
  .wr_addr    (reg_wdata[regwin_pkg::XADDR_W-1:0]),
  .reg_rdata  (reg_rdata),
  .reg_ready  (reg_ready),
  .dn_req     (dn_req),
  .dn_we      (dn_we),
  .dn_addr    (dn_addr),
  .dn_off     (dn_addr[regwin_pkg::LANE_W-1:0]),
  .dn_len     (dn_len),
  .dn_wdata   (dn_wdata),
  .dn_ack     (dn_ack)
);

// File: tb/regwin_bridge_bench.sv
module regwin_bridge_bench;
  localparam logic [7:0] O_BASE = 8'h40;
  localparam logic [7:0] O_CMD  = 8'h41;
  localparam logic [7:0] O_DATA = 8'h42;
  localparam logic [7:0] O_STAT = 8'h43;
  localparam logic [63:0] DONE  = 64'h8000_0000_0000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_sel = 1'b0, reg_we = 1'b0;
  logic [7:0] reg_off = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic reg_ready;
  logic dn_req, dn_we;
  logic [31:0] dn_addr;
  logic [3:0] dn_len;
  logic [63:0] dn_wdata;
  logic dn_ack = 1'b0;
  logic [63:0] dn_rdata = '0;

  int checks = 0;
  int fails = 0;
  int lat = 1;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    int          len;
    logic [63:0] wpk;
    logic [63:0] rpk;
  } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  regwin_bridge u_regwin_bridge (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_off(reg_off), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_ready(reg_ready), .dn_req(dn_req), .dn_we(dn_we), .dn_addr(dn_addr),
    .dn_len(dn_len), .dn_wdata(dn_wdata), .dn_ack(dn_ack), .dn_rdata(dn_rdata)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit rd, input int size, input logic [31:0] a);
    return {rd, 4'b0, 7'(size), 20'b0, a};
  endfunction

  function automatic int blen(input logic [31:0] a, input int size);
    int s = (size == 0) ? 1 : size;
    int room = 8 - int'(a[2:0]);
    return (s > room) ? room : s;
  endfunction

  function automatic logic [63:0] topmask(input int n);
    return ~64'h0 << (64 - 8 * n);
  endfunction

  task automatic wr(input logic [7:0] off, input logic [63:0] v, output bit stalled);
    stalled = 0;
    @(negedge clk);
    reg_sel = 1; reg_we = 1; reg_off = off; reg_wdata = v;
    #2;
    while (!reg_ready) begin
      stalled = 1;
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    reg_sel = 0; reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] off, output logic [63:0] v);
    @(negedge clk);
    reg_sel = 1; reg_we = 0; reg_off = off;
    #2;
    v = reg_rdata;
    reg_sel = 0;
  endtask

  task automatic wait_idle();
    logic [63:0] s;
    for (int n = 0; n < 200; n++) begin
      rd(O_STAT, s);
      if (s[63]) break;
    end
  endtask

  task automatic push_rd(input logic [31:0] a, input int size, input logic [63:0] rpk);
    exp_t e;
    e.we = 0; e.addr = a; e.len = blen(a, size); e.wpk = '0; e.rpk = rpk;
    q.push_back(e);
  endtask

  task automatic push_wr(input logic [31:0] a, input int size, input logic [63:0] v);
    exp_t e;
    e.we = 1; e.addr = a; e.len = blen(a, size);
    e.wpk = (v << (8 * int'(a[2:0]))) & topmask(e.len);
    e.rpk = '0;
    q.push_back(e);
  endtask

  // monitor / downstream responder: pops expected transfers and compares
  initial begin
    exp_t e;
    bit held;
    forever begin
      @(negedge clk);
      if (rst_n && dn_req) begin
        if (q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R4/R5 unexpected request actual=we%0d addr=%h expected=none", dn_we, dn_addr);
          e.we = dn_we; e.addr = dn_addr; e.len = int'(dn_len); e.wpk = dn_wdata; e.rpk = '0;
        end else begin
          e = q.pop_front();
        end
        chk("R4 R5 direction", 64'(dn_we), 64'(e.we));
        chk("R3 address", 64'(dn_addr), 64'(e.addr));
        chk("R8 length", 64'(dn_len), 64'(e.len));
        if (e.we) chk("R6 write lanes", dn_wdata, e.wpk);
        held = 1;
        for (int c = 0; c < lat; c++) begin
          @(negedge clk);
          if (!(dn_req && dn_we == e.we && dn_addr == e.addr && int'(dn_len) == e.len)) held = 0;
          if (e.we && dn_wdata != e.wpk) held = 0;
        end
        chk("R9 hold", 64'(held), 64'd1);
        dn_ack = 1; dn_rdata = e.rpk;
        @(negedge clk);
        dn_ack = 0; dn_rdata = '0;
        chk("R9 drop", 64'(dn_req), 64'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] v;
    bit st;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(O_STAT, v); chk("R10 idle status", v, DONE);
    rd(O_CMD, v);  chk("R1 cmd reset", v, 64'h0);
    rd(O_DATA, v); chk("R1 data reset", v, 64'h0);

    // write command only latches
    wr(O_CMD, mk(0, 4, 32'h1000_0003), st);
    rd(O_CMD, v); chk("R3 cmd readback", v, mk(0, 4, 32'h1000_0003));

    // data write triggers downstream write at lane offset 3
    push_wr(32'h1000_0003, 4, 64'h1122_3344_5566_7788);
    wr(O_DATA, 64'h1122_3344_5566_7788, st);
    wait_idle();
    rd(O_DATA, v); chk("R5 data latched", v, 64'h1122_3344_5566_7788);

    // byte read at offset 0, junk in unused packed bytes
    push_rd(32'h0000_03F8, 1, 64'hABCD_EF00_1122_3344);
    wr(O_CMD, mk(1, 1, 32'h0000_03F8), st);
    wait_idle();
    rd(O_DATA, v); chk("R7 byte read", v, 64'hAB00_0000_0000_0000);

    // halfword read at offset 6
    push_rd(32'h0000_0206, 2, 64'hCDEF_9999_0000_0000);
    wr(O_CMD, mk(1, 2, 32'h0000_0206), st);
    wait_idle();
    rd(O_DATA, v); chk("R7 lanes 6..7", v, 64'h0000_0000_0000_CDEF);

    // 8-byte read at offset 5 clipped to 3
    push_rd(32'h0000_0105, 8, 64'h0102_0304_0506_0708);
    wr(O_CMD, mk(1, 8, 32'h0000_0105), st);
    wait_idle();
    rd(O_DATA, v); chk("R8 clipped read", v, 64'h0000_0000_0001_0203);

    // size 0 write at offset 2 moves one byte
    wr(O_CMD, mk(0, 0, 32'h0000_0022), st);
    push_wr(32'h0000_0022, 0, 64'hA0B1_C2D3_E4F5_0617);
    wr(O_DATA, 64'hA0B1_C2D3_E4F5_0617, st);
    wait_idle();

    // read flag set: data write starts nothing
    push_rd(32'h0000_0009, 1, 64'h5A00_0000_0000_0000);
    wr(O_CMD, mk(1, 1, 32'h0000_0009), st);
    wait_idle();
    rd(O_DATA, v); chk("R7 offset 1", v, 64'h005A_0000_0000_0000);
    wr(O_DATA, 64'h1234, st);
    repeat (4) @(negedge clk);
    chk("R5 no write when read flag", 64'(dn_req), 64'd0);
    rd(O_DATA, v); chk("R5 data latched only", v, 64'h1234);

    // ignored writes
    wr(O_BASE, ~64'h0, st);
    wr(O_STAT, ~64'h0, st);
    wr(8'h50, ~64'h0, st);
    wr(8'h3F, ~64'h0, st);
    repeat (3) @(negedge clk);
    chk("R2 no request", 64'(dn_req), 64'd0);
    rd(O_CMD, v);  chk("R2 cmd kept", v, mk(1, 1, 32'h0000_0009));
    rd(O_DATA, v); chk("R2 data kept", v, 64'h1234);
    rd(O_STAT, v); chk("R2 status kept", v, DONE);
    rd(O_BASE, v); chk("R1 base zero", v, 64'h0);
    rd(8'h50, v);  chk("R1 outside zero", v, 64'h0);

    // stall behind a slow write
    lat = 6;
    wr(O_CMD, mk(0, 8, 32'h0000_0800), st);
    push_wr(32'h0000_0800, 8, 64'hD1D1_0000_0000_00D1);
    wr(O_DATA, 64'hD1D1_0000_0000_00D1, st);
    rd(O_STAT, v); chk("R10 busy status", v, 64'h0);
    push_wr(32'h0000_0800, 8, 64'h0000_D2D2_D2D2_0000);
    wr(O_DATA, 64'h0000_D2D2_D2D2_0000, st);
    chk("R11 stalled", 64'(st), 64'd1);
    wait_idle();
    rd(O_DATA, v); chk("R11 second write applied", v, 64'h0000_D2D2_D2D2_0000);
    lat = 1;
    repeat (4) @(negedge clk);
    chk("R4 R5 queue drained", 64'(q.size()), 64'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule